// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures how fast its own clock runs by comparing it against a slow, accurate reference clock, nominally 32768 Hz. The reference clock is divided by four into a tick. A window down-counter in the reference domain times a window of exactly 58 ticks. The window always opens on a tick edge, because the counter is loaded two ticks above the point where counting is allowed to begin. While the window is open, the fast clock drives a divide-by-177 prescaler, and every prescaler wrap adds one to a raw count.

When the window closes, the raw count is rounded and scaled to hertz by a multi-cycle shift-and-add multiplier. The result is published with a one-cycle done pulse. A second output gives the bus frequency, which is either equal to the core frequency or half of it, depending on a divider-select input. A measurement is started by a single-cycle pulse. Control crosses between the two clock domains as toggles through two-flop synchronizers.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, busy, done and overflow are 0, and core_hz and bus_hz are 0.
- R2: A start pulse while busy is 0 makes busy 1 on the next clock. Busy stays 1 until the cycle in which done is 1, and is 0 in that cycle.
- R3: The raw count equals the number of complete 177-cycle prescaler periods of clk that fit inside a gate of exactly 232 rclk periods (58 ticks of 4 rclk periods). The gate begins on a tick boundary.
- R4: core_hz equals ((raw + 2) >> 2) * 100000, so it is always a whole multiple of 100000.
- R5: bus_hz equals core_hz when bus_half (sampled at completion) is 0, and equals core_hz >> 1 when it is 1.
- R6: done is high for exactly one clock per measurement.
- R7: A start pulse while busy is 1 is ignored. The measurement in progress is neither restarted nor extended, and it produces exactly one done.
- R8: The raw count saturates at 2^RAW_W-1 instead of wrapping, and overflow reports 1 with that result. The saturation flag is cleared when the next measurement starts, so a later result that fits reports overflow 0.
- R9: core_hz, bus_hz and overflow change only in the cycle in which done is 1, and they hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being measured; the block's logic runs on it |
| rclk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start | input | 1 | Single-cycle request to begin a measurement |
| bus_half | input | 1 | 1 selects bus frequency = core / 2 |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| core_hz | output | 32 | Measured core frequency in Hz, rounded to 0.1 MHz |
| bus_hz | output | 32 | Derived bus frequency in Hz |
| overflow | output | 1 | Raw count saturated during the last measurement |

## Verification
The hardest situation to reach is a second start that lands in the middle of an open window. If it leaked through, it would reload the window counter and quietly stretch the gate. The bench issues such a pulse thousands of cycles after the first start and then requires both the single-window count and exactly one done. The bench keeps the reference period an exact multiple of the clk period and places the reference edges between clk edges. This gives a known gate length, so expected counts can be computed exactly, including rounding that goes up, rounding that goes down, and, in a narrow-counter instance, saturation.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_RUN   = 2'd1,
        MS_SCALE = 2'd2
    } meter_st_e;

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/fm_ref_window.sv
module fm_ref_window #(
    parameter int TICK_DIV  = 4,
    parameter int WIN_TICKS = 58
) (
    input  logic rclk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic gate,
    output logic exp_tgl
);
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam int CNT_W = $clog2(WIN_TICKS + 2);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_OPEN = CNT_W'(WIN_TICKS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             gate;
        logic             exp;
        logic             req_prev;
    } win_t;

    win_t r_d, r_q;
    logic req_s;
    logic tick;
    logic [CNT_W-1:0] cnt_dec;

    fm_sync #(.W(1)) u_req_sync (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_comb begin
        r_d      = r_q;
        tick     = (r_q.div == DIV_LAST);
        cnt_dec  = r_q.cnt - 1'b1;
        r_d.div  = tick ? '0 : r_q.div + 1'b1;
        r_d.req_prev = req_s;
        if ((req_s ^ r_q.req_prev) && !r_q.active) begin
            r_d.active = 1'b1;
            r_d.cnt    = CNT_LOAD;
            r_d.gate   = 1'b0;
        end else if (r_q.active && tick) begin
            if (r_q.cnt == '0) begin
                r_d.active = 1'b0;
                r_d.gate   = 1'b0;
                r_d.exp    = ~r_q.exp;
            end else begin
                r_d.cnt = cnt_dec;
                if (cnt_dec <= CNT_OPEN) begin
                    r_d.gate = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate    = r_q.gate;
    assign exp_tgl = r_q.exp;
endmodule

// File: rtl/fm_scale.sv
module fm_scale #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32,
    parameter int MULT  = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IN_W-1:0]  raw,
    output logic             rdy,
    output logic [OUT_W-1:0] result
);
    localparam int M_W   = $clog2(MULT + 1);
    localparam int IDX_W = $clog2(M_W);
    localparam logic [M_W-1:0]   MULT_V   = M_W'(MULT);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(M_W - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [OUT_W-1:0] sh;
        logic [OUT_W-1:0] acc;
        logic             rdy;
    } sc_t;

    sc_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.rdy = 1'b0;
        if (go) begin
            r_d.busy = 1'b1;
            r_d.idx  = '0;
            r_d.acc  = '0;
            r_d.sh   = ({{(OUT_W-IN_W){1'b0}}, raw} + OUT_W'(2)) >> 2;
        end else if (r_q.busy) begin
            if (MULT_V[r_q.idx]) begin
                r_d.acc = r_q.acc + r_q.sh;
            end
            r_d.sh = r_q.sh << 1;
            if (r_q.idx == IDX_LAST) begin
                r_d.busy = 1'b0;
                r_d.rdy  = 1'b1;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy    = r_q.rdy;
    assign result = r_q.acc;
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
    parameter int PRESCALE  = 177,
    parameter int TICK_DIV  = 4,
    parameter int WIN_TICKS = 58,
    parameter int RAW_W     = 16,
    parameter int HZ_W      = 32,
    parameter int HZ_STEP   = 100000
) (
    input  logic            clk,
    input  logic            rclk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bus_half,
    output logic            busy,
    output logic            done,
    output logic [HZ_W-1:0] core_hz,
    output logic [HZ_W-1:0] bus_hz,
    output logic            overflow
);
    import fm_pkg::*;

    localparam int PRE_W = $clog2(PRESCALE);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [RAW_W-1:0] RAW_MAX  = '1;

    typedef struct packed {
        meter_st_e        st;
        logic             tgl;
        logic [PRE_W-1:0] pre;
        logic [RAW_W-1:0] raw;
        logic             sat;
        logic             exp_prev;
        logic             done;
        logic [HZ_W-1:0]  core;
        logic [HZ_W-1:0]  bus;
        logic             ovf;
    } mtr_t;

    mtr_t r_d, r_q;
    logic gate_r, exp_r;
    logic gate_s, exp_s;
    logic sc_go, sc_rdy;
    logic [HZ_W-1:0] sc_res;

    fm_ref_window #(
        .TICK_DIV  (TICK_DIV),
        .WIN_TICKS (WIN_TICKS)
    ) u_window (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .req_tgl (r_q.tgl),
        .gate    (gate_r),
        .exp_tgl (exp_r)
    );

    fm_sync #(.W(2)) u_back_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gate_r, exp_r}),
        .q     ({gate_s, exp_s})
    );

    fm_scale #(
        .IN_W  (RAW_W),
        .OUT_W (HZ_W),
        .MULT  (HZ_STEP)
    ) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sc_go),
        .raw    (r_q.raw),
        .rdy    (sc_rdy),
        .result (sc_res)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.exp_prev = exp_s;
        sc_go        = 1'b0;
        unique case (r_q.st)
            MS_IDLE: begin
                if (start) begin
                    r_d.st  = MS_RUN;
                    r_d.tgl = ~r_q.tgl;
                    r_d.pre = '0;
                    r_d.raw = '0;
                    r_d.sat = 1'b0;
                end
            end
            MS_RUN: begin
                if (gate_s) begin
                    if (r_q.pre == PRE_LAST) begin
                        r_d.pre = '0;
                        if (r_q.raw == RAW_MAX) begin
                            r_d.sat = 1'b1;
                        end else begin
                            r_d.raw = r_q.raw + 1'b1;
                        end
                    end else begin
                        r_d.pre = r_q.pre + 1'b1;
                    end
                end
                if (exp_s ^ r_q.exp_prev) begin
                    r_d.st = MS_SCALE;
                    sc_go  = 1'b1;
                end
            end
            MS_SCALE: begin
                if (sc_rdy) begin
                    r_d.st   = MS_IDLE;
                    r_d.core = sc_res;
                    r_d.bus  = bus_half ? (sc_res >> 1) : sc_res;
                    r_d.ovf  = r_q.sat;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != MS_IDLE);
    assign done     = r_q.done;
    assign core_hz  = r_q.core;
    assign bus_hz   = r_q.bus;
    assign overflow = r_q.ovf;
endmodule

// File: rtl/clk_freq_meter_chk.sv
module clk_freq_meter_chk #(
    parameter int RAW_W   = 16,
    parameter int HZ_W    = 32,
    parameter int HZ_STEP = 100000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            bus_half,
    input logic            busy,
    input logic            done,
    input logic [HZ_W-1:0] core_hz,
    input logic [HZ_W-1:0] bus_hz,
    input logic            overflow
);
    localparam longint SAT_Q  = ((longint'(1) << RAW_W) + 1) >> 2;
    localparam logic [HZ_W-1:0] SAT_HZ = HZ_W'(SAT_Q * HZ_STEP);
    localparam logic [HZ_W-1:0] STEP_V = HZ_W'(HZ_STEP);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6
    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((core_hz % STEP_V) == '0));  // R4
    AST_BUS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_hz == ($past(bus_half) ? (core_hz >> 1) : core_hz)));  // R5
    AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (core_hz == SAT_HZ));  // R8
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(core_hz) && $stable(bus_hz) && $stable(overflow)));  // R9
endmodule

bind clk_freq_meter clk_freq_meter_chk #(
    .RAW_W   (RAW_W),
    .HZ_W    (HZ_W),
    .HZ_STEP (HZ_STEP)
) u_chk (.*);

// File: tb/clk_freq_meter_bench.sv
module clk_freq_meter_bench;
    localparam int GATE_REF = 232;   // 58 ticks x 4 reference periods
    localparam int PRE_DIV  = 177;
    localparam int STEP     = 100000;
    localparam int NARROW_W = 6;
    localparam int LIMIT    = 190000;

    logic clk = 1'b0;
    logic rclk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_half = 1'b0;
    int   rhalf = 128;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   dc_main = 0;
    int   dc_sat = 0;

    logic        busy_m, done_m, ovf_m;
    logic [31:0] core_m, bus_m;
    logic        busy_s, done_s, ovf_s;
    logic [31:0] core_s, bus_s;

    clk_freq_meter u_clk_freq_meter (
        .clk(clk), .rclk(rclk), .rst_n(rst_n), .start(start), .bus_half(bus_half),
        .busy(busy_m), .done(done_m), .core_hz(core_m), .bus_hz(bus_m), .overflow(ovf_m)
    );

    clk_freq_meter #(.RAW_W(NARROW_W)) u_narrow (
        .clk(clk), .rclk(rclk), .rst_n(rst_n), .start(start), .bus_half(bus_half),
        .busy(busy_s), .done(done_s), .core_hz(core_s), .bus_hz(bus_s), .overflow(ovf_s)
    );

    always #4 clk = ~clk;

    initial begin
        #2;
        forever #(rhalf) rclk = ~rclk;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_m) dc_main <= dc_main + 1;
        if (done_s) dc_sat <= dc_sat + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int hz_of(int raw);
        return ((raw + 2) / 4) * STEP;
    endfunction

    task automatic measure(int p, bit half, bit poke, string tag);
        int raw_m;
        int raw_s;
        logic [31:0] hold_c;
        logic [31:0] hold_b;
        raw_m = (GATE_REF * p) / PRE_DIV;
        raw_s = (raw_m > (1 << NARROW_W) - 1) ? (1 << NARROW_W) - 1 : raw_m;
        rhalf = p * 4;
        bus_half = half;
        repeat (4) @(posedge rclk);
        @(negedge clk);
        dc_main = 0;
        dc_sat = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R2 busy after start ", tag}, 32'(busy_m), 32'd1);
        if (poke) begin
            repeat (3000) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk({"R7 busy kept ", tag}, 32'(busy_m), 32'd1);
        end
        while ((dc_main == 0 || dc_sat == 0) && cyc < LIMIT) @(negedge clk);
        if (cyc >= LIMIT) begin
            chk({"watchdog ", tag}, 32'd0, 32'd1);
            return;
        end
        chk({"R3 R4 core ", tag}, core_m, 32'(hz_of(raw_m)));
        chk({"R5 bus ", tag}, bus_m, half ? 32'(hz_of(raw_m) / 2) : 32'(hz_of(raw_m)));
        chk({"R8 ovf wide ", tag}, 32'(ovf_m), 32'd0);
        chk({"R8 narrow core ", tag}, core_s, 32'(hz_of(raw_s)));
        chk({"R8 narrow ovf ", tag}, 32'(ovf_s), (raw_m > raw_s) ? 32'd1 : 32'd0);
        chk({"R2 idle at end ", tag}, 32'(busy_m), 32'd0);
        hold_c = core_m;
        hold_b = bus_m;
        bus_half = ~half;
        repeat (40) @(negedge clk);
        chk({"R6 R7 one done ", tag}, 32'(dc_main), 32'd1);
        chk({"R9 core held ", tag}, core_m, hold_c);
        chk({"R9 bus held ", tag}, bus_m, hold_b);
    endtask

    task automatic reset_check();
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy_m), 32'd0);
        chk("R1 done", 32'(done_m), 32'd0);
        chk("R1 core", core_m, 32'd0);
        chk("R1 bus", bus_m, 32'd0);
        chk("R1 ovf", 32'(ovf_m), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after release", 32'(busy_m), 32'd0);
    endtask

    initial begin
        reset_check();
        measure(32, 1'b0, 1'b0, "p32 round down");
        measure(100, 1'b1, 1'b0, "p100 half sat");
        measure(64, 1'b0, 1'b0, "p64 round up");
        measure(32, 1'b1, 1'b1, "p32 restart ignored");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule